// File: doc/BRIEF.md
# Dual-Group Programmable Clock Divider

This block derives two groups of divided clock waveforms from one fast input clock. Group A and group B each take a four-bit ratio code that picks one divide ratio from a fixed set: 1, 2, 4, 5, 8, 10, 16, 20, 32, 40 or 80. Each group drives five outputs, and each output has its own enable. The outputs are registered logic-level waveforms that run at one cycle of the input clock per count.

Group B can be shifted against group A in discrete steps. The number of steps available depends on B's ratio. If the ratio is a multiple of five, there are ratio/5 steps of five input cycles each. For any other ratio, there are as many steps as the ratio, each one input cycle long. The requested step count is reduced modulo the number of available steps.

The block registers every setting. When a ratio code or the phase offset changes, it raises a one-cycle resync pulse internally. That pulse reloads both group counters at the same edge, so the two groups stay aligned without an external reset. A ratio code outside the defined set is run as divide-by-1 and raises an error flag.

Top module: `dual_clk_divider`

## Requirements
- R1: Ratio codes 0 to 10 select divide ratios 1, 2, 4, 5, 8, 10, 16, 20, 32, 40 and 80 in that order. An enabled output of a group repeats with a period of exactly its ratio P in input clock cycles.
- R2: Within each period, an output is high for floor(P/2) cycles and then low for the rest. For P = 5 that is 2 cycles high and 3 low. For P = 1 an enabled output stays high.
- R3: Group B's ratio is set by its own code, independently of group A.
- R4: Group B starts its period k·s input cycles ahead of group A. Here k is the phase offset modulo η. For a multiple-of-five P, η = P/5 and s = 5; otherwise η = P and s = 1.
- R5: An output whose enable bit is 0 is held low. Each of the ten outputs has its own enable bit, and enables take effect without a resync.
- R6: Any change of either ratio code or of the phase offset is registered at the next rising edge (E0). Both groups then restart, and the output registered at edge E0+2+k shows count position k of the new pattern.
- R7: A ratio code above 10 makes its group divide by 1. It also sets cfg_err, which is visible after E0. cfg_err is low while both codes are valid.
- R8: While rst is high, all outputs and cfg_err are low.
- R9: All enabled outputs of one group carry identical waveforms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| ratio_a | input | 4 | Ratio code for group A |
| ratio_b | input | 4 | Ratio code for group B |
| phase_step | input | 7 | Requested phase steps of group B relative to A |
| en_a | input | 5 | Per-output enables, group A |
| en_b | input | 5 | Per-output enables, group B |
| clk_a | output | 5 | Divided outputs, group A |
| clk_b | output | 5 | Divided outputs, group B |
| cfg_err | output | 1 | A ratio code is outside the defined set |

## Verification
The assertions assume that settings change only between clock edges. They also assume that each setting is held long enough to be registered, so that every change in the registered configuration coincides with one resync pulse. The counter-range check also relies on the counter being out of range only in the cycle that the pulse reloads it. The bench drives every setting at falling edges and holds it through a full sampling window of at least two periods. It changes the configuration between successive windows, so each window starts from a known restart edge. The sweep covers all eleven ratio codes on group A, paired with several codes and offsets on group B, so that every step size and every modulo reduction is exercised.

// File: rtl/dg_pkg.sv
package dg_pkg;

  localparam int NUM_CODES = 11;

  // divide ratio selected by a code; undefined codes fall back to 1
  function automatic int ratio_of(input int code);
    case (code)
      0:       return 1;
      1:       return 2;
      2:       return 4;
      3:       return 5;
      4:       return 8;
      5:       return 10;
      6:       return 16;
      7:       return 20;
      8:       return 32;
      9:       return 40;
      10:      return 80;
      default: return 1;
    endcase
  endfunction

  function automatic logic code_ok(input int code);
    return (code >= 0) && (code < NUM_CODES);
  endfunction

  // ratios that are multiples of five step in groups of five input cycles
  function automatic logic fives_ratio(input int code);
    return (code == 3) || (code == 5) || (code == 7) || (code == 9) || (code == 10);
  endfunction

  function automatic int high_len(input int ratio);
    return (ratio == 1) ? 1 : ratio / 2;
  endfunction

endpackage

// File: rtl/dg_cfg.sv
module dg_cfg #(
  parameter int CODE_W = 4,
  parameter int OFS_W  = 7,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] ratio_a,
  input  logic [CODE_W-1:0] ratio_b,
  input  logic [OFS_W-1:0]  phase_step,
  output logic              sync,
  output logic [CNT_W-1:0]  per_a,
  output logic [CNT_W-1:0]  per_b,
  output logic [CNT_W-1:0]  hi_a,
  output logic [CNT_W-1:0]  hi_b,
  output logic [CNT_W-1:0]  pre_b,
  output logic              err
);

  localparam int CFG_W = 2 * CODE_W + OFS_W;

  logic [CODE_W-1:0] code_a_q, code_b_q;
  logic [OFS_W-1:0]  ofs_q;
  logic              sync_q, err_q;
  logic [CFG_W-1:0]  cfg_now, cfg_reg;

  assign cfg_now = {ratio_a, ratio_b, phase_step};
  assign cfg_reg = {code_a_q, code_b_q, ofs_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      code_a_q <= '0;
      code_b_q <= '0;
      ofs_q    <= '0;
      sync_q   <= 1'b1;
      err_q    <= 1'b0;
    end else begin
      code_a_q <= ratio_a;
      code_b_q <= ratio_b;
      ofs_q    <= phase_step;
      sync_q   <= (cfg_now != cfg_reg);
      err_q    <= !dg_pkg::code_ok(int'(ratio_a)) || !dg_pkg::code_ok(int'(ratio_b));
    end
  end

  int ra, rb, eta_b, step_b, shift_b;

  always_comb begin
    ra      = dg_pkg::ratio_of(int'(code_a_q));
    rb      = dg_pkg::ratio_of(int'(code_b_q));
    eta_b   = dg_pkg::fives_ratio(int'(code_b_q)) ? rb / 5 : rb;
    step_b  = dg_pkg::fives_ratio(int'(code_b_q)) ? 5 : 1;
    shift_b = (int'(ofs_q) % eta_b) * step_b;
  end

  assign per_a = CNT_W'(ra);
  assign per_b = CNT_W'(rb);
  assign hi_a  = CNT_W'(dg_pkg::high_len(ra));
  assign hi_b  = CNT_W'(dg_pkg::high_len(rb));
  assign pre_b = CNT_W'(shift_b);
  assign sync  = sync_q;
  assign err   = err_q;

  // R6
  chg_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_reg != $past(cfg_reg)) |-> sync_q);

  // R4
  pre_range_chk: assert property (@(posedge clk) disable iff (rst)
    pre_b < per_b);

endmodule

// File: rtl/dg_group.sv
module dg_group #(
  parameter int NOUT  = 5,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync,
  input  logic [CNT_W-1:0] per,
  input  logic [CNT_W-1:0] hi,
  input  logic [CNT_W-1:0] pre,
  input  logic [NOUT-1:0]  en,
  output logic [NOUT-1:0]  out
);

  logic [CNT_W-1:0] cnt_q;
  logic             wave;
  logic [NOUT-1:0]  out_q;

  always_ff @(posedge clk) begin
    if (rst)                        cnt_q <= '0;
    else if (sync)                  cnt_q <= pre;
    else if (cnt_q >= per - 1'b1)   cnt_q <= '0;
    else                            cnt_q <= cnt_q + 1'b1;
  end

  assign wave = (cnt_q < hi);

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) out_q[i] <= 1'b0;
      else     out_q[i] <= en[i] & wave;
    end

    // R5
    dis_low_chk: assert property (@(posedge clk) disable iff (rst)
      !en[i] |=> !out_q[i]);
  end

  assign out = out_q;

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    !sync |-> (cnt_q < per));

  // R9
  grp_match_chk: assert property (@(posedge clk) disable iff (rst)
    (&en) |=> ((&out_q) || !(|out_q)));

  // R2
  full_rate_chk: assert property (@(posedge clk) disable iff (rst)
    (per == 1 && !sync && en[0]) |=> out_q[0]);

endmodule

// File: rtl/dual_clk_divider.sv
module dual_clk_divider #(
  parameter int NOUT   = 5,
  parameter int CODE_W = 4,
  parameter int OFS_W  = 7,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] ratio_a,
  input  logic [CODE_W-1:0] ratio_b,
  input  logic [OFS_W-1:0]  phase_step,
  input  logic [NOUT-1:0]   en_a,
  input  logic [NOUT-1:0]   en_b,
  output logic [NOUT-1:0]   clk_a,
  output logic [NOUT-1:0]   clk_b,
  output logic              cfg_err
);

  logic             sync;
  logic [CNT_W-1:0] per_a, per_b, hi_a, hi_b, pre_b;

  dg_cfg #(.CODE_W(CODE_W), .OFS_W(OFS_W), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst(rst),
    .ratio_a(ratio_a), .ratio_b(ratio_b), .phase_step(phase_step),
    .sync(sync), .per_a(per_a), .per_b(per_b),
    .hi_a(hi_a), .hi_b(hi_b), .pre_b(pre_b), .err(cfg_err)
  );

  dg_group #(.NOUT(NOUT), .CNT_W(CNT_W)) u_grp_a (
    .clk(clk), .rst(rst), .sync(sync),
    .per(per_a), .hi(hi_a), .pre({CNT_W{1'b0}}),
    .en(en_a), .out(clk_a)
  );

  dg_group #(.NOUT(NOUT), .CNT_W(CNT_W)) u_grp_b (
    .clk(clk), .rst(rst), .sync(sync),
    .per(per_b), .hi(hi_b), .pre(pre_b),
    .en(en_b), .out(clk_b)
  );

  // R7
  bad_code_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (per_a == 1 || per_b == 1));

  // R8
  rst_quiet_chk: assert property (@(posedge clk)
    rst |=> (!(|clk_a) && !(|clk_b) && !cfg_err));

endmodule

// File: tb/dual_clk_divider_bench.sv
module dual_clk_divider_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] ratio_a = '0, ratio_b = '0;
  logic [6:0] phase_step = '0;
  logic [4:0] en_a = '0, en_b = '0;
  logic [4:0] clk_a, clk_b;
  logic       cfg_err;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dual_clk_divider u_dual_clk_divider (
    .clk(clk), .rst(rst), .ratio_a(ratio_a), .ratio_b(ratio_b),
    .phase_step(phase_step), .en_a(en_a), .en_b(en_b),
    .clk_a(clk_a), .clk_b(clk_b), .cfg_err(cfg_err)
  );

  function automatic int m_ratio(input int c);
    int tbl[11] = '{1, 2, 4, 5, 8, 10, 16, 20, 32, 40, 80};
    return (c >= 0 && c < 11) ? tbl[c] : 1;
  endfunction

  function automatic logic m_wave(input int p, input int pos);
    int h = (p == 1) ? 1 : p / 2;
    return (pos % p) < h;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive a new setting, then compare outputs position by position
  task automatic run_cfg(input int ca, input int cb, input int ofs,
                         input logic [4:0] ea, input logic [4:0] eb, input int len);
    int pa, pb, eta, stp, pre;
    logic [4:0] xa, xb;
    pa  = m_ratio(ca);
    pb  = m_ratio(cb);
    eta = (pb % 5 == 0) ? pb / 5 : pb;
    stp = (pb % 5 == 0) ? 5 : 1;
    pre = (ofs % eta) * stp;
    @(negedge clk);
    ratio_a    = 4'(ca);
    ratio_b    = 4'(cb);
    phase_step = 7'(ofs);
    en_a       = ea;
    en_b       = eb;
    @(posedge clk); #1;
    // R7 error flag after the registering edge
    check("R7 cfg_err", int'(cfg_err), (ca > 10 || cb > 10) ? 1 : 0);
    @(posedge clk);
    for (int k = 0; k < len; k++) begin
      @(posedge clk); #1;
      xa = ea & {5{m_wave(pa, k)}};
      xb = eb & {5{m_wave(pb, pre + k)}};
      // R1 R2 R5 R6 R9 group A pattern
      check("R1 R2 R5 R6 R9 group A", int'(clk_a), int'(xa));
      // R3 R4 R5 group B pattern and phase
      check("R3 R4 R5 group B", int'(clk_b), int'(xb));
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R8 reset state
    check("R8 clk_a in reset", int'(clk_a), 0);
    check("R8 clk_b in reset", int'(clk_b), 0);
    check("R8 cfg_err in reset", int'(cfg_err), 0);
    @(negedge clk);
    rst = 1'b0;

    for (int ca = 0; ca < 11; ca++) begin
      for (int j = 0; j < 3; j++) begin
        int cb, ofs, pmax;
        cb   = (ca + j * 4) % 11;
        ofs  = (ca * 7 + j * 13 + 1) % 128;
        pmax = (m_ratio(ca) > m_ratio(cb)) ? m_ratio(ca) : m_ratio(cb);
        run_cfg(ca, cb, ofs, 5'(5'h1F ^ ca), 5'(5'h1F ^ (j * 9)), 2 * pmax + 3);
      end
    end

    // R4 offset larger than the step count, multiple-of-five ratio
    run_cfg(4, 10, 99, 5'h1F, 5'h1F, 170);
    // R4 same ratios, shifted offset: restart with a different phase
    run_cfg(4, 10, 100, 5'h1F, 5'h1F, 170);
    // R7 undefined code on group A runs at full rate
    run_cfg(13, 2, 1, 5'h1F, 5'h0F, 12);
    // R7 undefined code on group B
    run_cfg(3, 15, 2, 5'h15, 5'h1F, 12);
    // R7 flag clears with valid codes again
    run_cfg(1, 3, 2, 5'h1F, 5'h1F, 12);
    // R5 all outputs disabled
    run_cfg(5, 6, 4, 5'h00, 5'h00, 40);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule